// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wakeup Start-Up Delay

This block decides when a small processor core may run. Software requests one of two sleep modes through a register write strobe. In the deep mode (HALT) the oscillator is switched off along with every clock. In the light mode (IDLE) the oscillator and the prescaler keep running and only the core clock is gated. A wakeup input, which may arrive asynchronously, is synchronised to the oscillator clock. It then starts the return to normal operation.

Leaving the deep mode first turns on only the oscillator enable. The core clock stays gated until a start-up delay has run out. The delay is 256 instruction cycles, and one instruction cycle is ten oscillator periods. When the resistor/capacitor clock source is chosen, the delay applies only if a configuration bit requests it. That bit is cleared by reset. The block also drives the watchdog inhibit and the mode of the clock-input pad. It reports its state on a two-bit status output.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, pm_state reads 0 (ACTIVE), osc_en and core_clk_en are 1, and halt_flag, idle_flag, wdt_inhibit, pad_force_high and pad_tristate are 0.
- R2: A reg_wr pulse with reg_halt_bit=1 while ACTIVE (and halt_disable=0) makes the next cycle show pm_state=1 (HALT), osc_en=0, core_clk_en=0 and halt_flag=1.
- R3: After a wakeup from HALT with a delayed clock source, the status shows pm_state=2 (OSC_STARTUP) with osc_en=1 and core_clk_en=0. This lasts exactly 2560 oscillator cycles before core_clk_en returns to 1. Delayed sources are clk_opt 0 (crystal), 1 (external), 3 (treated as external), and 2 (RC) when the delay bit is 1.
- R4: wake_async passes through a two-stage synchroniser. If it is raised before rising edge n, osc_en rises after edge n+2 and not earlier.
- R5: With clk_opt=2 (RC) and the delay bit at 0 (its reset value), a wakeup from HALT raises osc_en and core_clk_en in the same cycle. A cfg_wr pulse loads cfg_clkdly into the delay bit.
- R6: While halt_disable=1, a halt write has no effect: halt_flag stays 0 and the core clock keeps running.
- R7: A reg_wr pulse with reg_idle_bit=1 while ACTIVE gives pm_state=3 (IDLE), osc_en=1, core_clk_en=0 and idle_flag=1. A synchronised wakeup then returns to ACTIVE with no start-up delay.
- R8: If both bits are written in the same pulse, HALT is entered.
- R9: wdt_inhibit is 1 exactly while pm_state is HALT or OSC_STARTUP.
- R10: In HALT, pad_force_high=1 when clk_opt=2. Otherwise pad_tristate=1. Outside HALT both are 0.
- R11: halt_flag and idle_flag clear by themselves when the wakeup sequence completes. A write while not ACTIVE, or a write with both bits 0, has no effect.
- R12: wake_async has no effect while ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_async | input | 1 | Wakeup request, asynchronous, level |
| reg_wr | input | 1 | Mode flag write strobe |
| reg_halt_bit | input | 1 | Value written to the HALT flag |
| reg_idle_bit | input | 1 | Value written to the IDLE flag |
| cfg_wr | input | 1 | Start-up delay bit write strobe |
| cfg_clkdly | input | 1 | Value for the RC start-up delay bit |
| halt_disable | input | 1 | Option: blocks HALT entry |
| clk_opt | input | 2 | Clock source: 0 crystal, 1 external, 2 RC, 3 external |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| wdt_inhibit | output | 1 | Watchdog inhibit |
| pad_force_high | output | 1 | Clock-input pad forced high |
| pad_tristate | output | 1 | Clock-input pad tri-stated |
| halt_flag | output | 1 | HALT flag read value |
| idle_flag | output | 1 | IDLE flag read value |
| pm_state | output | 2 | 0 ACTIVE, 1 HALT, 2 OSC_STARTUP, 3 IDLE |

## Verification
The assertions check on every cycle the relations between outputs. The watchdog inhibit and the core clock gate never overlap. The two pad modes are exclusive. The start-up state always keeps the oscillator on with the core gated. The halt-disable option never lets HALT be entered. They also check that the prescaler and the start-up count stay in range and that HALT is left only when the synchronised wakeup is seen. Some behaviour depends on elapsed time or on the sequence of events, and only the bench scenarios can show it. This covers the exact 2560-cycle release delay, the two-edge synchroniser latency, the RC shortcut with the reset value of the delay bit, and the flags clearing themselves at the end of a sequence.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      PM_ACTIVE  = 2'd0,
      PM_HALT    = 2'd1,
      PM_STARTUP = 2'd2,
      PM_IDLE    = 2'd3
   } pm_state_e;

   localparam logic [1:0] CLKSRC_RC = 2'd2;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_prescaler.sv
module lpm_prescaler #(
   parameter int DIVIDE = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (DIVIDE < 2) begin : g_bad_divide
         $error("lpm_prescaler: DIVIDE must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(DIVIDE);
   localparam logic [CW-1:0] LAST = CW'(DIVIDE - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == LAST);

   // R3: prescale count never leaves its range
   a_r3_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R3: count returns to zero once stopped
   a_r3_prescale_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);

endmodule

// File: rtl/lpm_delay_timer.sv
module lpm_delay_timer #(
   parameter int LOAD_VALUE = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic expired
);

   generate
      if (LOAD_VALUE < 1) begin : g_bad_load
         $error("lpm_delay_timer: LOAD_VALUE must be at least 1");
      end
   endgenerate

   localparam int TW = $clog2(LOAD_VALUE + 1);
   localparam logic [TW-1:0] START = TW'(LOAD_VALUE);

   logic [TW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         remain_q <= '0;
      else if (load)                      remain_q <= START;
      else if (tick && remain_q != '0)    remain_q <= remain_q - 1'b1;
   end

   assign expired = tick && (remain_q == TW'(1));

   // R3: a load always restarts at the full start-up count
   a_r3_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> remain_q == START);

   // R3: remaining count never exceeds the load value
   a_r3_timer_range: assert property (@(posedge clk) disable iff (!rst_n)
      remain_q <= START);

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
   import lpm_pkg::*;
#(
   parameter int PRESCALE       = 10,
   parameter int STARTUP_CYCLES = 256,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk_osc,
   input  logic       rst_n,
   input  logic       wake_async,
   input  logic       reg_wr,
   input  logic       reg_halt_bit,
   input  logic       reg_idle_bit,
   input  logic       cfg_wr,
   input  logic       cfg_clkdly,
   input  logic       halt_disable,
   input  logic [1:0] clk_opt,
   output logic       osc_en,
   output logic       core_clk_en,
   output logic       wdt_inhibit,
   output logic       pad_force_high,
   output logic       pad_tristate,
   output logic       halt_flag,
   output logic       idle_flag,
   output logic [1:0] pm_state
);

   pm_state_e state_q, state_d;
   logic      wake_s;
   logic      clkdly_q;
   logic      presc_run;
   logic      instr_tick;
   logic      timer_load;
   logic      timer_done;
   logic      src_is_rc;
   logic      skip_delay;
   logic      halt_req;
   logic      idle_req;

   lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .d_async (wake_async),
      .q_sync  (wake_s)
   );

   lpm_prescaler #(.DIVIDE(PRESCALE)) u_presc (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .run   (presc_run),
      .tick  (instr_tick)
   );

   lpm_delay_timer #(.LOAD_VALUE(STARTUP_CYCLES)) u_timer (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .load    (timer_load),
      .tick    (instr_tick),
      .expired (timer_done)
   );

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n)      clkdly_q <= 1'b0;
      else if (cfg_wr) clkdly_q <= cfg_clkdly;
   end

   assign src_is_rc  = (clk_opt == CLKSRC_RC);
   assign skip_delay = src_is_rc && !clkdly_q;
   assign halt_req   = reg_wr && reg_halt_bit && !halt_disable;
   assign idle_req   = reg_wr && reg_idle_bit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_ACTIVE: begin
            if (halt_req)      state_d = PM_HALT;
            else if (idle_req) state_d = PM_IDLE;
         end
         PM_HALT: begin
            if (wake_s) state_d = skip_delay ? PM_ACTIVE : PM_STARTUP;
         end
         PM_STARTUP: begin
            if (timer_done) state_d = PM_ACTIVE;
         end
         PM_IDLE: begin
            if (wake_s) state_d = PM_ACTIVE;
         end
         default: state_d = PM_ACTIVE;
      endcase
   end

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) state_q <= PM_ACTIVE;
      else        state_q <= state_d;
   end

   assign timer_load = (state_q == PM_HALT) && (state_d == PM_STARTUP);
   assign presc_run  = (state_q == PM_STARTUP) || (state_q == PM_IDLE);

   assign osc_en         = (state_q != PM_HALT);
   assign core_clk_en    = (state_q == PM_ACTIVE);
   assign halt_flag      = (state_q == PM_HALT) || (state_q == PM_STARTUP);
   assign idle_flag      = (state_q == PM_IDLE);
   assign wdt_inhibit    = halt_flag;
   assign pad_force_high = (state_q == PM_HALT) && src_is_rc;
   assign pad_tristate   = (state_q == PM_HALT) && !src_is_rc;
   assign pm_state       = state_q;

   // R9: watchdog inhibit and running core never overlap
   a_r9_wdt_vs_core: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !(wdt_inhibit && core_clk_en));

   // R10: pad modes are exclusive
   a_r10_pad_exclusive: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !(pad_force_high && pad_tristate));

   // R3: start-up keeps the oscillator on and the core gated
   a_r3_startup_outputs: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (pm_state == 2'd2) |-> (osc_en && !core_clk_en));

   // R6: with the disable option HALT is never entered from ACTIVE
   a_r6_halt_blocked: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (halt_disable && state_q == PM_ACTIVE) |=> (pm_state != 2'd1));

   // R4: HALT is held until the synchronised wakeup appears
   a_r4_halt_holds: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (state_q == PM_HALT && !wake_s) |=> (pm_state == 2'd1));

   // R12: wakeup while ACTIVE without a write keeps ACTIVE
   a_r12_active_stays: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (state_q == PM_ACTIVE && !reg_wr) |=> core_clk_en);

   // R3: start-up ends only on an instruction tick
   a_r3_release_on_tick: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (state_q == PM_STARTUP && !instr_tick) |=> (pm_state == 2'd2));

endmodule

// File: tb/test_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module test_lpm_wake_ctrl;

   logic       clk_osc = 1'b0;
   logic       rst_n;
   logic       wake_async, reg_wr, reg_halt_bit, reg_idle_bit;
   logic       cfg_wr, cfg_clkdly, halt_disable;
   logic [1:0] clk_opt;
   logic       osc_en, core_clk_en, wdt_inhibit, pad_force_high, pad_tristate;
   logic       halt_flag, idle_flag;
   logic [1:0] pm_state;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk_osc = ~clk_osc;

   lpm_wake_ctrl i_lpm_wake_ctrl (
      .clk_osc, .rst_n, .wake_async, .reg_wr, .reg_halt_bit, .reg_idle_bit,
      .cfg_wr, .cfg_clkdly, .halt_disable, .clk_opt, .osc_en, .core_clk_en,
      .wdt_inhibit, .pad_force_high, .pad_tristate, .halt_flag, .idle_flag,
      .pm_state
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic do_reset();
      rst_n = 1'b0; wake_async = 0; reg_wr = 0; reg_halt_bit = 0; reg_idle_bit = 0;
      cfg_wr = 0; cfg_clkdly = 0; halt_disable = 0; clk_opt = 2'd0;
      repeat (3) @(negedge clk_osc);
      rst_n = 1'b1;
      @(negedge clk_osc);
   endtask

   task automatic write_flags(input logic h, input logic i);
      reg_wr = 1; reg_halt_bit = h; reg_idle_bit = i;
      @(negedge clk_osc);
      reg_wr = 0; reg_halt_bit = 0; reg_idle_bit = 0;
   endtask

   // raise wake; check two-edge sync latency (R4); return at negedge after osc_en rises
   task automatic raise_wake();
      wake_async = 1;
      @(negedge clk_osc);
      chk("R4", "osc_en after 1 edge", osc_en, 0);
      @(negedge clk_osc);
      chk("R4", "osc_en after 2 edges", osc_en, 0);
      @(negedge clk_osc);
      chk("R4", "osc_en after 3 edges", osc_en, 1);
   endtask

   task automatic count_startup(input string req);
      int n = 0;
      chk(req, "pm_state in start-up", pm_state, 2);
      chk("R9", "wdt_inhibit in start-up", wdt_inhibit, 1);
      chk("R10", "pads in start-up", {pad_force_high, pad_tristate}, 0);
      while (!core_clk_en && n < 10000) begin
         n++;
         @(negedge clk_osc);
      end
      chk(req, "start-up cycles", n, 2560);
      chk("R11", "halt_flag after release", halt_flag, 0);
      chk("R9", "wdt_inhibit after release", wdt_inhibit, 0);
      wake_async = 0;
      repeat (3) @(negedge clk_osc);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "pm_state", pm_state, 0);
      chk("R1", "osc/core", {osc_en, core_clk_en}, 3);
      chk("R1", "flags", {halt_flag, idle_flag}, 0);
      chk("R1", "wdt/pads", {wdt_inhibit, pad_force_high, pad_tristate}, 0);
   endtask

   task automatic t_halt_crystal();
      do_reset();
      clk_opt = 2'd0;
      write_flags(1, 0);
      chk("R2", "pm_state", pm_state, 1);
      chk("R2", "osc/core", {osc_en, core_clk_en}, 0);
      chk("R2", "halt_flag", halt_flag, 1);
      chk("R9", "wdt_inhibit in HALT", wdt_inhibit, 1);
      chk("R10", "pad tristate crystal", {pad_force_high, pad_tristate}, 1);
      write_flags(0, 1);
      chk("R11", "idle write in HALT ignored", pm_state, 1);
      raise_wake();
      count_startup("R3");
   endtask

   task automatic t_rc_nodelay();
      do_reset();
      clk_opt = 2'd2;
      write_flags(1, 0);
      chk("R10", "pad forced high RC", {pad_force_high, pad_tristate}, 2);
      raise_wake();
      chk("R5", "core released with osc", core_clk_en, 1);
      chk("R5", "pm_state", pm_state, 0);
      wake_async = 0;
      repeat (3) @(negedge clk_osc);
   endtask

   task automatic t_rc_delay();
      do_reset();
      clk_opt = 2'd2;
      cfg_wr = 1; cfg_clkdly = 1;
      @(negedge clk_osc);
      cfg_wr = 0; cfg_clkdly = 0;
      write_flags(1, 0);
      raise_wake();
      count_startup("R3");
   endtask

   task automatic t_external3();
      do_reset();
      clk_opt = 2'd3;
      write_flags(1, 0);
      chk("R10", "pad tristate opt 3", {pad_force_high, pad_tristate}, 1);
      raise_wake();
      count_startup("R3");
   endtask

   task automatic t_halt_disable();
      do_reset();
      halt_disable = 1;
      write_flags(1, 0);
      chk("R6", "halt_flag", halt_flag, 0);
      chk("R6", "core_clk_en", core_clk_en, 1);
      chk("R6", "pm_state", pm_state, 0);
      halt_disable = 0;
   endtask

   task automatic t_idle();
      do_reset();
      write_flags(0, 1);
      chk("R7", "pm_state", pm_state, 3);
      chk("R7", "osc/core", {osc_en, core_clk_en}, 2);
      chk("R7", "idle_flag", idle_flag, 1);
      chk("R9", "wdt_inhibit in IDLE", wdt_inhibit, 0);
      write_flags(1, 0);
      chk("R11", "halt write in IDLE ignored", pm_state, 3);
      wake_async = 1;
      repeat (2) @(negedge clk_osc);
      chk("R7", "still idle before sync", pm_state, 3);
      @(negedge clk_osc);
      chk("R7", "active after wake", pm_state, 0);
      chk("R11", "idle_flag cleared", idle_flag, 0);
      wake_async = 0;
      repeat (3) @(negedge clk_osc);
   endtask

   task automatic t_priority();
      do_reset();
      write_flags(1, 1);
      chk("R8", "both written", pm_state, 1);
      raise_wake();
      count_startup("R3");
   endtask

   task automatic t_wake_active();
      do_reset();
      wake_async = 1;
      repeat (6) @(negedge clk_osc);
      chk("R12", "wake in ACTIVE", {pm_state, core_clk_en}, 1);
      wake_async = 0;
      repeat (3) @(negedge clk_osc);
      write_flags(0, 0);
      chk("R11", "zero write", pm_state, 0);
   endtask

   initial begin
      t_reset();
      t_halt_crystal();
      t_rc_nodelay();
      t_rc_delay();
      t_external3();
      t_halt_disable();
      t_idle();
      t_priority();
      t_wake_active();
      finish_run();
   end

endmodule